// File: doc/BRIEF.md
# Line-Idle Elastic Buffer Reset Controller

This block sits beside a serial receiver and decides when the receive elastic buffer must be held in reset. Each clock cycle it samples a flag that reports whether the line is in electrical idle. When the line has been idle for long enough, it raises the buffer reset. Once the reset is high, it waits until the line has carried non-idle data for long enough before it drops the reset again.

The two waiting times are set apart from each other by two 4-bit thresholds, which gives the reset hysteresis. A short idle glitch does not flush the buffer, and a short burst of activity on a dead line does not release it. Any break in the condition being timed restarts that count from zero. The block does not include the idle detector or the buffer itself.

Top module: `idle_bufrst_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `buf_rst` is low after that edge and both persistence counts are cleared. After `rst` is released, a full run is needed again before `buf_rst` changes.
- R2: With `buf_rst` low and `arm_len` = N (1 to 15), `buf_rst` goes high at the rising edge that samples the N-th consecutive cycle with `line_idle` = 1.
- R3: With `buf_rst` high and `release_len` = M (1 to 15), `buf_rst` goes low at the rising edge that samples the M-th consecutive cycle with `line_idle` = 0.
- R4: While `buf_rst` is low, one sampled cycle with `line_idle` = 0 clears the idle count, so a new idle run needs the full N cycles.
- R5: While `buf_rst` is high, one sampled cycle with `line_idle` = 1 clears the good-data count, so a new good run needs the full M cycles.
- R6: A threshold value of 0 behaves as 1: a single qualifying cycle is enough.
- R7: `buf_rst` changes only when a run completes. Idle cycles while it is high, and good cycles while it is low, leave it unchanged.
- R8: The idle count advances only while `buf_rst` is low, and the good-data count only while it is high. Each count is zero when its run starts, so after a release the next assert needs a fresh run of N idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_idle | input | 1 | 1 = the line is in electrical idle this cycle |
| arm_len | input | 4 | Idle cycles needed before the reset is raised (0 counts as 1) |
| release_len | input | 4 | Good cycles needed before the reset is dropped (0 counts as 1) |
| buf_rst | output | 1 | Reset to the elastic buffer, active high |

## Verification
The assertions assume that `line_idle` is a clean, synchronous level that is already valid at each rising edge. They also assume that `arm_len` and `release_len` stay constant while a run is being timed, so that the length of a run is well defined. The bench drives every input on the falling edge. It changes the thresholds only while the run that uses them is at zero, either just after reset or after a run has completed, and it reads `buf_rst` shortly after each rising edge.

// File: rtl/idle_bufrst_pkg.sv
`timescale 1ns/1ps
package idle_bufrst_pkg;

  // A programmed length of zero still demands one cycle of persistence.
  function automatic int unsigned eff_len(input int unsigned thr);
    return (thr == 0) ? 1 : thr;
  endfunction

  // True when the cycle now sampled completes a run: 'done' cycles were
  // already seen, and this cycle is one more.
  function automatic logic run_complete(input int unsigned done,
                                        input int unsigned thr);
    return (done + 1) >= eff_len(thr);
  endfunction

endpackage

// File: rtl/persist_timer.sv
`timescale 1ns/1ps
module persist_timer
  import idle_bufrst_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          cond,
  input  logic [CW-1:0] thr,
  output logic          expire,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;
  logic          counting;

  assign counting = enable && cond;
  assign expire   = counting && run_complete(32'(cnt_q), 32'(thr));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!counting || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/hyst_state.sv
`timescale 1ns/1ps
module hyst_state (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_ev,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (set_ev) begin
      q <= 1'b1;
    end else if (clr_ev) begin
      q <= 1'b0;
    end
  end

endmodule

// File: rtl/idle_bufrst_ctrl.sv
`timescale 1ns/1ps
module idle_bufrst_ctrl #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_idle,
  input  logic [LEN_W-1:0] arm_len,
  input  logic [LEN_W-1:0] release_len,
  output logic             buf_rst
);

  // Named internal events for the checker.
  logic             set_ev;
  logic             clr_ev;
  logic [LEN_W-1:0] set_cnt;
  logic [LEN_W-1:0] clr_cnt;

  // Idle run: timed only while the buffer is running.
  persist_timer #(.CW(LEN_W)) idle_run_i (
    .clk    (clk),
    .rst    (rst),
    .enable (!buf_rst),
    .cond   (line_idle),
    .thr    (arm_len),
    .expire (set_ev),
    .cnt_o  (set_cnt)
  );

  // Good-data run: timed only while the buffer is held in reset.
  persist_timer #(.CW(LEN_W)) good_run_i (
    .clk    (clk),
    .rst    (rst),
    .enable (buf_rst),
    .cond   (!line_idle),
    .thr    (release_len),
    .expire (clr_ev),
    .cnt_o  (clr_cnt)
  );

  hyst_state state_i (
    .clk    (clk),
    .rst    (rst),
    .set_ev (set_ev),
    .clr_ev (clr_ev),
    .q      (buf_rst)
  );

endmodule

// File: rtl/idle_bufrst_chk.sv
`timescale 1ns/1ps
module idle_bufrst_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             line_idle,
  input logic [LEN_W-1:0] arm_len,
  input logic [LEN_W-1:0] release_len,
  input logic             buf_rst,
  input logic             set_ev,
  input logic             clr_ev,
  input logic [LEN_W-1:0] set_cnt,
  input logic [LEN_W-1:0] clr_cnt
);

  // R1: reset clears the output
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !buf_rst);

  // R2: a rise follows a sampled idle cycle
  a_r2_rise_on_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_rst) |-> $past(line_idle));

  // R3: a fall outside reset follows a sampled good cycle
  a_r3_fall_on_good: assert property (@(posedge clk) disable iff (rst)
    ($fell(buf_rst) && !$past(rst)) |-> !$past(line_idle));

  // R6: a length of 0 or 1 arms on the first idle cycle
  a_r6_short_arm: assert property (@(posedge clk) disable iff (rst)
    ((arm_len <= LEN_W'(1)) && line_idle && !buf_rst) |=> buf_rst);

  // R6: a length of 0 or 1 releases on the first good cycle
  a_r6_short_release: assert property (@(posedge clk) disable iff (rst)
    ((release_len <= LEN_W'(1)) && !line_idle && buf_rst) |=> !buf_rst);

  // R7: no event, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_ev && !clr_ev) |=> $stable(buf_rst));

  // R8: each count advances only on its own side of the output
  a_r8_idle_cnt_side: assert property (@(posedge clk) disable iff (rst)
    (set_cnt != '0) |-> !buf_rst);
  a_r8_good_cnt_side: assert property (@(posedge clk) disable iff (rst)
    (clr_cnt != '0) |-> buf_rst);

  // R4: a good cycle while low restarts the idle count
  a_r4_idle_restart: assert property (@(posedge clk) disable iff (rst)
    (!line_idle && !buf_rst) |=> (set_cnt == '0));

  // R5: an idle cycle while high restarts the good count
  a_r5_good_restart: assert property (@(posedge clk) disable iff (rst)
    (line_idle && buf_rst) |=> (clr_cnt == '0));

endmodule

bind idle_bufrst_ctrl idle_bufrst_chk #(.LEN_W(LEN_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .line_idle   (line_idle),
  .arm_len     (arm_len),
  .release_len (release_len),
  .buf_rst     (buf_rst),
  .set_ev      (set_ev),
  .clr_ev      (clr_ev),
  .set_cnt     (set_cnt),
  .clr_cnt     (clr_cnt)
);

// File: tb/idle_bufrst_ctrl_tb_top.sv
`timescale 1ns/1ps
module idle_bufrst_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_idle = 1'b0;
  logic [3:0] arm_len = 4'd4;
  logic [3:0] release_len = 4'd4;
  logic       buf_rst;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  idle_bufrst_ctrl dut_i (
    .clk         (clk),
    .rst         (rst),
    .line_idle   (line_idle),
    .arm_len     (arm_len),
    .release_len (release_len),
    .buf_rst     (buf_rst)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: buf_rst=%0b expected %0b", tag, got, exp);
    end
  endtask

  // One cycle: drive on the falling edge, read just after the rising edge.
  task automatic cyc(input logic idle);
    @(negedge clk);
    line_idle = idle;
    @(posedge clk);
    #1;
  endtask

  task automatic cycles(input logic idle, input int n);
    for (int i = 0; i < n; i++) cyc(idle);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    line_idle = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: output low out of reset, good data keeps it low
  task automatic t_reset();
    do_reset();
    #1;
    check(buf_rst, 1'b0, "R1 after reset");
    cycles(1'b0, 20);
    check(buf_rst, 1'b0, "R7 good data while low");
  endtask

  // R2 and R3 at a given pair of lengths
  task automatic t_runs(input int n, input int m);
    arm_len = 4'(n);
    release_len = 4'(m);
    do_reset();
    cycles(1'b1, n - 1);
    check(buf_rst, 1'b0, "R2 one short of arm length");
    cyc(1'b1);
    check(buf_rst, 1'b1, "R2 armed at arm length");
    cycles(1'b1, 20);
    check(buf_rst, 1'b1, "R7 idle while high");
    cycles(1'b0, m - 1);
    check(buf_rst, 1'b1, "R3 one short of release length");
    cyc(1'b0);
    check(buf_rst, 1'b0, "R3 released at release length");
  endtask

  // R4: broken idle run restarts
  task automatic t_arm_break();
    arm_len = 4'd5;
    release_len = 4'd2;
    do_reset();
    cycles(1'b1, 4);
    cyc(1'b0);
    cycles(1'b1, 4);
    check(buf_rst, 1'b0, "R4 idle run restarted");
    cyc(1'b1);
    check(buf_rst, 1'b1, "R4 full run after break");
  endtask

  // R5: broken good run restarts
  task automatic t_release_break();
    arm_len = 4'd1;
    release_len = 4'd6;
    do_reset();
    cyc(1'b1);
    check(buf_rst, 1'b1, "R5 setup armed");
    cycles(1'b0, 5);
    cyc(1'b1);
    cycles(1'b0, 5);
    check(buf_rst, 1'b1, "R5 good run restarted");
    cyc(1'b0);
    check(buf_rst, 1'b0, "R5 full run after break");
  endtask

  // R6: zero lengths act as one
  task automatic t_zero();
    arm_len = 4'd0;
    release_len = 4'd0;
    do_reset();
    cyc(1'b1);
    check(buf_rst, 1'b1, "R6 arm length zero");
    cyc(1'b0);
    check(buf_rst, 1'b0, "R6 release length zero");
  endtask

  // R8 and R1: counts start from zero after a release and after reset
  task automatic t_fresh_counts();
    arm_len = 4'd3;
    release_len = 4'd3;
    do_reset();
    cycles(1'b1, 3);
    check(buf_rst, 1'b1, "R8 setup armed");
    cycles(1'b0, 3);
    check(buf_rst, 1'b0, "R8 setup released");
    cycles(1'b1, 2);
    check(buf_rst, 1'b0, "R8 idle count fresh after release");
    cyc(1'b1);
    check(buf_rst, 1'b1, "R8 armed after full fresh run");
    cycles(1'b0, 2);
    do_reset();
    #1;
    check(buf_rst, 1'b0, "R1 reset while high");
    cycles(1'b1, 2);
    do_reset();
    cycles(1'b1, 2);
    check(buf_rst, 1'b0, "R1 idle count cleared by reset");
    cyc(1'b1);
    check(buf_rst, 1'b1, "R1 full run after reset");
  endtask

  initial begin
    t_reset();
    t_runs(4, 4);
    t_runs(1, 7);
    t_runs(15, 15);
    t_runs(9, 2);
    t_arm_break();
    t_release_break();
    t_zero();
    t_fresh_counts();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule